// File: doc/BRIEF.md
# Serial Command Bus Peripheral Receiver

This block is the peripheral end of a four-wire host bus with an active-low select, a serial clock, a data input from the host and a reply data output to the host. All four host wires are asynchronous to the block. The select, clock and data inputs are brought into the system clock domain through two-flop synchronisers, and edges of the serial clock are found there. The system clock must therefore run several times faster than the serial clock.

Each transaction opens with an address byte. The address decides how long the transaction is. A low address range holds one-byte commands, which are reported as a strobe. A write window of addresses takes two further data bytes into a small register file. A read window returns two bytes from that register file on the reply line. Addresses outside all three ranges are one byte long and do nothing. Nothing is acted on until select returns high. At that moment the block commits the transaction only if exactly the expected number of clock rising edges was seen. The reply pin itself is tristated outside the block under control of the enable output.

Top module: `sercmd_slave`

## Requirements
- R1: Every byte from the host is taken most significant bit first, one bit on each rising edge of the serial clock while select is low. The address byte comes first.
- R2: An address of WR_BASE+i (i below NREGS) followed by two bytes loads register i with {first byte, second byte}. The first byte is the high half. Register i appears on regs_q bits [16*i+15 : 16*i].
- R3: After an address of RD_BASE+i, the block presents register i on sdo, most significant bit first. Each reply bit is valid at the next rising clock edge, so 16 reply edges follow the address byte. A read changes no register.
- R4: An address below CMD_LIMIT is a one-byte command. When it is committed, cmd_valid is high for exactly one system clock and cmd_code carries the address.
- R5: Nothing takes effect while select is low. Registers hold their value and cmd_valid stays low until select rises.
- R6: sdo_oe is low while select is high. It is raised only once select is low and the serial clock has been seen low.
- R7: Transfers work the same whether the serial clock idles high or low.
- R8: If the number of rising edges differs from the length implied by the address (too few or too many), the transaction is dropped. No register changes and no command strobe is given.
- R9: An address outside the command, write and read ranges changes no register and gives no strobe.
- R10: After reset all registers read zero, sdo_oe is low and cmd_valid is low.
- R11: The serial clock may pause for any time between bytes inside one transaction, and this does not change the result.
- R12: Serial clock and data activity while select is high has no effect on the registers, on the strobe, or on the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Host select, active low |
| sck | input | 1 | Host serial clock |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial reply data to host |
| sdo_oe | output | 1 | Output enable for the reply pin driver |
| cmd_valid | output | 1 | One-cycle strobe for a committed one-byte command |
| cmd_code | output | 8 | Address of the committed command |
| regs_q | output | NREGS*16 | Register file contents, register 0 in the low bits |

## Verification
The bench goes after the length check in several ways. It sends write frames cut short and frames padded with extra bits. A block that trusted the address alone would write garbage, and one that counted bits loosely would accept the padded frame. It runs transactions with both clock idle levels and with long pauses between bytes. A receiver that counted falling edges or timed out inside a transaction would lose a bit there. It samples the registers after the last bit but before select rises, and it toggles the clock while deselected. An early commit, or a counter that does not clear, shows up as a changed register or a misread next frame. Reads are compared bit for bit against a model of the register file, which exposes a reply that is shifted one position or sent in the wrong order.

// File: rtl/scb_pkg.sv
package scb_pkg;

   typedef enum logic [1:0] {
      K_CMD  = 2'd0,
      K_WR   = 2'd1,
      K_RD   = 2'd2,
      K_NONE = 2'd3
   } kind_e;

   function automatic kind_e classify(input logic [7:0] a, input int nregs,
                                      input int cmd_limit, input int wr_base,
                                      input int rd_base);
      int v;
      v = int'(a);
      if (v < cmd_limit)                       return K_CMD;
      if (v >= wr_base && v < wr_base + nregs) return K_WR;
      if (v >= rd_base && v < rd_base + nregs) return K_RD;
      return K_NONE;
   endfunction

endpackage

// File: rtl/scb_sync.sv
module scb_sync #(
   parameter int           W    = 3,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar g = 0; g < W; g++) begin : g_bit
      logic [1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st <= {2{INIT[g]}};
         else        st <= {st[0], d[g]};
      end
      assign q[g] = st[1];
   end
endmodule

// File: rtl/scb_regfile.sv
module scb_regfile #(
   parameter int NREGS = 4,
   parameter int DW    = 16,
   parameter int IW    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IW-1:0]       wr_idx,
   input  logic [DW-1:0]       wr_data,
   input  logic [IW-1:0]       rd_idx,
   output logic [DW-1:0]       rd_data,
   output logic [NREGS*DW-1:0] regs_flat
);
   logic [DW-1:0] mem [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  mem[g] <= '0;
         else if (wr_en && int'(wr_idx) == g)         mem[g] <= wr_data;
      end
      assign regs_flat[g*DW +: DW] = mem[g];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREGS; i++)
         if (int'(rd_idx) == i) rd_data = mem[i];
   end

   // R5 / R8: contents move only in the cycle after a commit strobe
   assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/scb_frame.sv
module scb_frame import scb_pkg::*; #(
   parameter int NREGS     = 4,
   parameter int DW        = 16,
   parameter int IW        = 2,
   parameter int CMD_LIMIT = 'h40,
   parameter int WR_BASE   = 'h40,
   parameter int RD_BASE   = 'h80
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_s,
   input  logic          sck_s,
   input  logic          sdi_s,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic [DW-1:0] wr_data,
   output logic [IW-1:0] rd_idx,
   input  logic [DW-1:0] rd_data,
   output logic          cmd_valid,
   output logic [7:0]    cmd_code,
   output logic          sdo,
   output logic          sdo_oe
);
   localparam int FULL = 8 + DW;
   localparam int CW   = $clog2(FULL + 2);
   localparam logic [CW-1:0] SAT = CW'(FULL + 1);

   logic            sck_q, sel_q, seen_low, oe_q;
   logic [CW-1:0]   cnt;
   logic [FULL-1:0] rx;
   logic [DW-1:0]   tx;
   logic            sck_rise, sel_rise;
   logic [7:0]      nxt_addr, cmd_addr;
   kind_e           k_now;
   logic            len_ok;

   assign sck_rise = ~sel_s & sck_s & ~sck_q;
   assign sel_rise = sel_s & ~sel_q;
   assign nxt_addr = {rx[6:0], sdi_s};
   assign rd_idx   = IW'(int'(nxt_addr) - RD_BASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0; sel_q <= 1'b1; seen_low <= 1'b0; oe_q <= 1'b0;
         cnt <= '0; rx <= '0; tx <= '0;
      end else begin
         sck_q <= sck_s;
         sel_q <= sel_s;
         if (sel_s) begin
            cnt <= '0; seen_low <= 1'b0; oe_q <= 1'b0; tx <= '0;
         end else begin
            if (!sck_s) seen_low <= 1'b1;
            oe_q <= seen_low | ~sck_s;
            if (sck_rise) begin
               rx <= {rx[FULL-2:0], sdi_s};
               if (cnt != SAT) cnt <= cnt + 1'b1;
               if (cnt == CW'(7) &&
                   classify(nxt_addr, NREGS, CMD_LIMIT, WR_BASE, RD_BASE) == K_RD)
                  tx <= rd_data;
               else if (cnt >= CW'(8))
                  tx <= {tx[DW-2:0], 1'b0};
            end
         end
      end
   end

   // decide the commit from the count reached when select rises
   assign cmd_addr = (cnt == CW'(8)) ? rx[7:0] : rx[FULL-1 -: 8];
   assign k_now    = classify(cmd_addr, NREGS, CMD_LIMIT, WR_BASE, RD_BASE);
   assign len_ok   = (k_now == K_WR || k_now == K_RD) ? (cnt == CW'(FULL))
                                                       : (cnt == CW'(8));
   assign wr_en     = sel_rise & len_ok & (k_now == K_WR);
   assign wr_idx    = IW'(int'(cmd_addr) - WR_BASE);
   assign wr_data   = rx[DW-1:0];
   assign cmd_valid = sel_rise & len_ok & (k_now == K_CMD);
   assign cmd_code  = cmd_addr;
   assign sdo       = oe_q & tx[DW-1];
   assign sdo_oe    = oe_q;

   assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> !sdo_oe);
   assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);
   assert_cnt_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> (cnt == '0));
   assert_one_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, cmd_valid}));
endmodule

// File: rtl/sercmd_slave.sv
module sercmd_slave #(
   parameter int NREGS     = 4,
   parameter int CMD_LIMIT = 'h40,
   parameter int WR_BASE   = 'h40,
   parameter int RD_BASE   = 'h80
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_n,
   input  logic                 sck,
   input  logic                 sdi,
   output logic                 sdo,
   output logic                 sdo_oe,
   output logic                 cmd_valid,
   output logic [7:0]           cmd_code,
   output logic [NREGS*16-1:0]  regs_q
);
   localparam int DW = 16;
   localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

   if (NREGS < 1 || NREGS > 64) begin : g_bad_nregs
      $error("NREGS out of range");
   end
   if (CMD_LIMIT > WR_BASE || WR_BASE + NREGS > RD_BASE || RD_BASE + NREGS > 256) begin : g_bad_map
      $error("address windows overlap or exceed the address byte");
   end

   logic [2:0]    sync_q;
   logic          wr_en;
   logic [IW-1:0] wr_idx, rd_idx;
   logic [DW-1:0] wr_data, rd_data;

   scb_sync #(.W(3), .INIT(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sel_n, sck, sdi}), .q(sync_q));

   scb_frame #(.NREGS(NREGS), .DW(DW), .IW(IW), .CMD_LIMIT(CMD_LIMIT),
               .WR_BASE(WR_BASE), .RD_BASE(RD_BASE)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .sel_s(sync_q[2]), .sck_s(sync_q[1]), .sdi_s(sync_q[0]),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .sdo(sdo), .sdo_oe(sdo_oe));

   scb_regfile #(.NREGS(NREGS), .DW(DW), .IW(IW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .regs_flat(regs_q));
endmodule

// File: tb/sim_sercmd_slave.sv
`timescale 1ns/1ps
module sim_sercmd_slave;
   localparam int NREGS = 4;
   localparam int H     = 6;

   logic clk = 0, rst_n = 0, sel_n = 1, sck = 0, sdi = 0;
   logic sdo, sdo_oe, cmd_valid;
   logic [7:0] cmd_code;
   logic [NREGS*16-1:0] regs_q;

   logic [15:0] model [NREGS];
   int checks = 0, fails = 0, cmd_cnt = 0;
   logic [7:0] last_code = '0;
   bit done = 0;

   always #4 clk = ~clk;

   sercmd_slave #(.NREGS(NREGS)) u0 (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .regs_q(regs_q));

   always @(negedge clk) if (cmd_valid) begin cmd_cnt++; last_code = cmd_code; end

   function automatic logic [NREGS*16-1:0] model_flat();
      logic [NREGS*16-1:0] f;
      for (int i = 0; i < NREGS; i++) f[i*16 +: 16] = model[i];
      return f;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic t_open(input bit pol);
      sck = pol; sdi = 0;
      repeat (H) @(negedge clk);
      sel_n = 0;
      repeat (H) @(negedge clk);
   endtask

   task automatic t_bits(input logic [31:0] tx, input int n, input bit gap, output logic [15:0] rx);
      rx = '0;
      for (int i = 0; i < n; i++) begin
         sck = 0; sdi = tx[n-1-i];
         repeat (H) @(negedge clk);
         sck = 1;
         if (i >= 8) rx = {rx[14:0], sdo};
         repeat (H) @(negedge clk);
         if (gap && (i % 8) == 7) repeat (5*H) @(negedge clk);
      end
   endtask

   task automatic t_close(input bit pol);
      sck = pol;
      repeat (H) @(negedge clk);
      sel_n = 1;
      repeat (3*H) @(negedge clk);
   endtask

   task automatic frame(input logic [31:0] tx, input int n, input bit pol, input bit gap,
                        output logic [15:0] rx);
      t_open(pol); t_bits(tx, n, gap, rx); t_close(pol);
   endtask

   initial begin
      int unsigned s;
      logic [15:0] rx, d;
      int idx, c0, n;
      bit pol, gap;
      logic [7:0] a;
      s = $urandom(32'd4242);
      for (int i = 0; i < NREGS; i++) model[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(regs_q == '0, "R10 regs", 64'(regs_q), 64'(0));
      chk(sdo_oe == 0 && cmd_valid == 0, "R10 outputs", {sdo_oe, cmd_valid}, 0);

      // R6 / R7 enable with idle-high clock
      t_open(1'b1);
      chk(sdo_oe == 0, "R6 oe before clock low", sdo_oe, 0);
      sck = 0; repeat (H) @(negedge clk);
      chk(sdo_oe == 1, "R6 oe after clock low", sdo_oe, 1);
      sck = 1; repeat (H) @(negedge clk);
      t_close(1'b1);
      chk(sdo_oe == 0, "R6 oe after deselect", sdo_oe, 0);

      // R1 R2 R5 directed write, checked before select rises
      t_open(1'b0);
      t_bits({8'h00, 8'h41, 16'hA5C3}, 24, 1'b0, rx);
      repeat (4) @(negedge clk);
      chk(regs_q == '0 && cmd_cnt == 0, "R5 no early commit", 64'(regs_q), 64'(0));
      t_close(1'b0);
      model[1] = 16'hA5C3;
      chk(regs_q == model_flat(), "R2 R1 write reg1", 64'(regs_q), 64'(model_flat()));

      // R3 read back with idle-high clock and pauses (R7 R11)
      frame({8'h00, 8'h81, 16'h0}, 24, 1'b1, 1'b1, rx);
      chk(rx == 16'hA5C3, "R3 R11 read reg1", rx, 16'hA5C3);
      chk(regs_q == model_flat(), "R3 read keeps regs", 64'(regs_q), 64'(model_flat()));

      // R4 command strobe
      c0 = cmd_cnt;
      frame({24'h0, 8'h2D}, 8, 1'b0, 1'b0, rx);
      chk(cmd_cnt == c0 + 1 && last_code == 8'h2D, "R4 command", {cmd_cnt[7:0], last_code}, {8'(c0 + 1), 8'h2D});

      // R8 short write and padded command
      c0 = cmd_cnt;
      frame({8'h0, 8'h42, 16'h1234}, 20, 1'b0, 1'b0, rx);
      chk(regs_q == model_flat(), "R8 short write dropped", 64'(regs_q), 64'(model_flat()));
      frame({23'h0, 8'h11, 1'b1}, 9, 1'b1, 1'b0, rx);
      chk(cmd_cnt == c0, "R8 padded command dropped", cmd_cnt, c0);

      // R12 clock and data while deselected
      c0 = cmd_cnt;
      for (int i = 0; i < 11; i++) begin
         sck = ~sck; sdi = ~sdi; repeat (H) @(negedge clk);
      end
      repeat (3*H) @(negedge clk);
      chk(regs_q == model_flat() && cmd_cnt == c0, "R12 idle activity", 64'(regs_q), 64'(model_flat()));
      frame({8'h00, 8'h43, 16'h0F0F}, 24, 1'b0, 1'b0, rx);
      model[3] = 16'h0F0F;
      chk(regs_q == model_flat(), "R12 next frame intact", 64'(regs_q), 64'(model_flat()));

      // random mix
      for (int t = 0; t < 48; t++) begin
         pol = 1'($urandom % 2); gap = 1'($urandom % 2);
         idx = int'($urandom % NREGS); d = 16'($urandom);
         c0 = cmd_cnt;
         case ($urandom % 5)
            0: begin
               frame({8'h0, 8'(8'h40 + idx), d}, 24, pol, gap, rx);
               model[idx] = d;
               chk(regs_q == model_flat(), "R2 R7 random write", 64'(regs_q), 64'(model_flat()));
            end
            1: begin
               frame({8'h0, 8'(8'h80 + idx), 16'h0}, 24, pol, gap, rx);
               chk(rx == model[idx], "R3 R7 random read", rx, model[idx]);
            end
            2: begin
               a = 8'($urandom % 8'h40);
               frame({24'h0, a}, 8, pol, gap, rx);
               chk(cmd_cnt == c0 + 1 && last_code == a, "R4 random command", {cmd_cnt[7:0], last_code}, {8'(c0 + 1), a});
            end
            3: begin
               n = ($urandom % 2) ? int'(9 + $urandom % 15) : 25;
               frame({7'h0, 8'(8'h40 + idx), d, 1'b1} >> (25 - n), n, pol, gap, rx);
               chk(regs_q == model_flat() && cmd_cnt == c0, "R8 random bad length", 64'(regs_q), 64'(model_flat()));
            end
            default: begin
               a = ($urandom % 2) ? 8'(8'h44 + $urandom % 8'h3C) : 8'(8'h84 + $urandom % 8'h7C);
               frame({24'h0, a}, 8, pol, gap, rx);
               chk(regs_q == model_flat() && cmd_cnt == c0, "R9 unused address", 64'(regs_q), 64'(model_flat()));
            end
         endcase
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule